// File: doc/BRIEF.md
# UART Serial Boot Download Loader

This block receives a boot image over a single serial line and places it in on-chip RAM. It contains its own baud-tick divider and a 16x oversampling UART receiver. The stream starts with a three-byte length header, followed by that many payload bytes. The loader turns the header into a 24-bit byte count. It then issues one RAM write for each payload byte, at rising byte addresses that start at zero.

After the final payload byte has been written, the loader raises a one-cycle completion pulse. That pulse asks the surrounding chip to exchange the boot-ROM and RAM address regions. The stream carries no checksum, so every received byte is accepted. A byte whose stop bit is wrong is still used, but it sets a sticky error flag. Once the pulse has been issued, the loader ignores the line until the next reset.

Top module: `uart_boot_loader`

## Requirements
- R1: The first three received bytes form the payload length N, with the first byte as bits 23..16, the second as bits 15..8 and the third as bits 7..0. These header bytes are never written to RAM.
- R2: Payload byte k (counting from 0) is written with its received value at address k modulo 2^ADDR_W. Each write holds `ramWrEn` high for exactly one cycle.
- R3: Exactly N writes are issued for a length of N.
- R4: `doneSwap` is a single-cycle pulse and occurs once per download. For N > 0 it is high in the cycle right after the final write enable. For N = 0 it is issued after the third header byte and no write takes place.
- R5: After `doneSwap`, further received bytes cause no write, no new pulse and no change to `frameErr`, until reset.
- R6: A byte whose stop bit samples low is still counted and stored. It also sets `frameErr`, which then stays high until reset.
- R7: The line is sampled on a tick every CLK_DIV clocks, 16 ticks per bit. A start bit is confirmed at its midpoint (8th tick), so a low pulse shorter than half a bit is ignored. Data bits arrive LSB first and are sampled at mid-bit.
- R8: During and right after reset, `ramWrEn`, `doneSwap` and `frameErr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (20 MHz in the nominal setup) |
| rstN | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| ramWrEn | output | 1 | RAM write enable, one cycle per payload byte |
| ramWrAddr | output | ADDR_W | RAM byte address |
| ramWrData | output | 8 | RAM write data |
| doneSwap | output | 1 | One-cycle download-done / region-swap request |
| frameErr | output | 1 | Sticky bad-stop-bit flag |

## Verification
Two things can coincide. The final payload byte can carry a bad stop bit, so storing it, raising the error flag and ending the download all happen on the same received byte. The bench provokes this by corrupting the stop bit of the last byte of a download. It then checks that the byte is still written, that `frameErr` rises and stays high, and that `doneSwap` follows the write by exactly one cycle. It also sends bytes after completion and checks that they change neither the write count nor the pulse count.

// File: rtl/boot_loader_pkg.sv
package boot_loader_pkg;
  localparam int LEN_W = 24;

  typedef struct packed {
    logic shiftLen;
    logic storeByte;
    logic markFrameErr;
  } loadStrobe_t;
endpackage

// File: rtl/boot_baud_gen.sv
module boot_baud_gen #(
  parameter int CLK_DIV = 22
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      tick   <= 1'b0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
      tick   <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
      tick   <= 1'b0;
    end
  end

  generate
    if (CLK_DIV > 1) begin : g_gap
      // R7: ticks are spaced, never back to back
      p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/boot_uart_rx.sv
module boot_uart_rx #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxd,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       stopBad
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI} rxState_t;

  rxState_t   rxState;
  logic [1:0] syncReg;
  logic       rxIn;
  logic [CNT_W-1:0] smpCnt;
  logic [2:0] bitIdx;
  logic [7:0] shiftReg;

  assign rxIn = syncReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= 2'b11;
    else       syncReg <= {syncReg[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState   <= RX_IDLE;
      smpCnt    <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      stopBad   <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      case (rxState)
        RX_IDLE: if (tick && !rxIn) begin
          rxState <= RX_START;
          smpCnt  <= '0;
        end
        RX_START: if (tick) begin
          if (smpCnt == MID_CNT - 1'b1) begin
            smpCnt  <= '0;
            bitIdx  <= '0;
            rxState <= rxIn ? RX_IDLE : RX_DATA;
          end else begin
            smpCnt <= smpCnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (smpCnt == LAST_CNT) begin
            smpCnt   <= '0;
            shiftReg <= {rxIn, shiftReg[7:1]};
            bitIdx   <= bitIdx + 1'b1;
            if (bitIdx == 3'd7) rxState <= RX_STOP;
          end else begin
            smpCnt <= smpCnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (smpCnt == LAST_CNT) begin
            smpCnt    <= '0;
            byteValid <= 1'b1;
            byteData  <= shiftReg;
            stopBad   <= !rxIn;
            rxState   <= rxIn ? RX_IDLE : RX_WAITHI;
          end else begin
            smpCnt <= smpCnt + 1'b1;
          end
        end
        RX_WAITHI: if (rxIn) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // R7: one valid strobe per received frame
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
endmodule

// File: rtl/boot_load_ctrl.sv
module boot_load_ctrl
  import boot_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        stopBad,
  input  logic        lenNextZero,
  input  logic        lastByte,
  output loadStrobe_t strobe,
  output logic        doneSwap
);
  typedef enum logic [1:0] {LD_HDR, LD_LOAD, LD_FIN, LD_DONE} ldState_t;

  ldState_t   ldState;
  logic [1:0] hdrIdx;

  always_comb begin
    strobe = '0;
    if (byteValid) begin
      case (ldState)
        LD_HDR:  strobe.shiftLen  = 1'b1;
        LD_LOAD: strobe.storeByte = 1'b1;
        default: ;
      endcase
      strobe.markFrameErr = stopBad && (ldState == LD_HDR || ldState == LD_LOAD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldState  <= LD_HDR;
      hdrIdx   <= '0;
      doneSwap <= 1'b0;
    end else begin
      doneSwap <= (ldState == LD_FIN);
      case (ldState)
        LD_HDR: if (byteValid) begin
          hdrIdx <= hdrIdx + 1'b1;
          if (hdrIdx == 2'd2) ldState <= lenNextZero ? LD_FIN : LD_LOAD;
        end
        LD_LOAD: if (byteValid && lastByte) ldState <= LD_FIN;
        LD_FIN:  ldState <= LD_DONE;
        default: ldState <= LD_DONE;
      endcase
    end
  end

  // R4: the completion request never lasts two cycles
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneSwap |=> !doneSwap);
  // R5: once finished, nothing is stored
  p_quiet_after_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneSwap |-> !strobe.storeByte && !strobe.markFrameErr);
  // R1: header and payload strobes never coincide
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftLen, strobe.storeByte}));
endmodule

// File: rtl/boot_load_path.sv
module boot_load_path
  import boot_loader_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadStrobe_t       strobe,
  input  logic [7:0]        byteData,
  output logic              lenNextZero,
  output logic              lastByte,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [7:0]        ramWrData,
  output logic              frameErr
);
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] wrCount;

  assign lenNextZero = ({lenReg[LEN_W-9:0], byteData} == '0);
  assign lastByte    = (wrCount == lenReg - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg    <= '0;
      wrCount   <= '0;
      ramWrEn   <= 1'b0;
      ramWrAddr <= '0;
      ramWrData <= '0;
      frameErr  <= 1'b0;
    end else begin
      ramWrEn <= strobe.storeByte;
      if (strobe.shiftLen) lenReg <= {lenReg[LEN_W-9:0], byteData};
      if (strobe.storeByte) begin
        ramWrAddr <= wrCount[ADDR_W-1:0];
        ramWrData <= byteData;
        wrCount   <= wrCount + 1'b1;
      end
      if (strobe.markFrameErr) frameErr <= 1'b1;
    end
  end

  // R6: error flag is sticky
  p_frame_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);
  // R2: each write lasts exactly one cycle
  p_write_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |=> !ramWrEn);
  // R3: the write count never passes the header length
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |-> wrCount < lenReg);
endmodule

// File: rtl/uart_boot_loader.sv
module uart_boot_loader
  import boot_loader_pkg::*;
#(
  parameter int CLK_DIV    = 22,
  parameter int OVERSAMPLE = 16,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic [7:0]        ramWrData,
  output logic              doneSwap,
  output logic              frameErr
);
  logic        tick;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        stopBad;
  logic        lenNextZero;
  logic        lastByte;
  loadStrobe_t strobe;

  boot_baud_gen #(.CLK_DIV(CLK_DIV)) i_baud (
    .clk(clk), .rstN(rstN), .tick(tick));

  boot_uart_rx #(.OVERSAMPLE(OVERSAMPLE)) i_rx (
    .clk(clk), .rstN(rstN), .tick(tick), .rxd(rxd),
    .byteValid(byteValid), .byteData(byteData), .stopBad(stopBad));

  boot_load_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .stopBad(stopBad),
    .lenNextZero(lenNextZero), .lastByte(lastByte),
    .strobe(strobe), .doneSwap(doneSwap));

  boot_load_path #(.ADDR_W(ADDR_W)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .lenNextZero(lenNextZero), .lastByte(lastByte),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .frameErr(frameErr));
endmodule

// File: tb/test_uart_boot_loader.sv
module test_uart_boot_loader;
  localparam int CLK_DIV = 2;
  localparam int ADDR_W  = 8;
  localparam int BIT_CYC = 16 * CLK_DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxd = 1'b1;
  logic ramWrEn, doneSwap, frameErr;
  logic [ADDR_W-1:0] ramWrAddr;
  logic [7:0] ramWrData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wrCnt, dataBad, doneCnt, wrAfterDone, lastWrCyc, doneCyc, curSeed;

  always #2.5 clk = ~clk;

  uart_boot_loader #(.CLK_DIV(CLK_DIV), .OVERSAMPLE(16), .ADDR_W(ADDR_W)) i_uart_boot_loader (
    .clk(clk), .rstN(rstN), .rxd(rxd), .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .ramWrData(ramWrData), .doneSwap(doneSwap), .frameErr(frameErr));

  function automatic logic [7:0] expByte(int seed, int k);
    return 8'((k * (2 * seed + 1) + seed) & 255);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rstN) begin
      wrCnt = 0; dataBad = 0; doneCnt = 0; wrAfterDone = 0; lastWrCyc = -1; doneCyc = -1;
    end else begin
      if (ramWrEn) begin
        if (doneCnt > 0) wrAfterDone++;
        if (ramWrAddr != ADDR_W'(wrCnt) || ramWrData != expByte(curSeed, wrCnt)) dataBad++;
        wrCnt++;
        lastWrCyc = cyc;
      end
      if (doneSwap) begin
        doneCnt++;
        doneCyc = cyc;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit goodStop);
    rxd = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rxd = goodStop;
    repeat (BIT_CYC) @(negedge clk);
    rxd = 1'b1;
    repeat (goodStop ? BIT_CYC / 2 : 2 * BIT_CYC) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    rxd  = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 wrEn in reset", int'(ramWrEn), 0);
    check("R8 done in reset", int'(doneSwap), 0);
    check("R8 frameErr in reset", int'(frameErr), 0);
    rstN = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
    check("R8 idle after reset", int'(ramWrEn | doneSwap | frameErr), 0);
  endtask

  task automatic runLoad(input int n, input int seed, input int badIdx, input int extra, input bit glitch);
    logic [23:0] len;
    len = 24'(n);
    curSeed = seed;
    doReset();
    if (glitch) begin
      rxd = 1'b0;
      repeat (BIT_CYC / 4) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BIT_CYC) @(negedge clk);
      check("R7 short low pulse ignored", wrCnt + int'(frameErr), 0);
    end
    sendByte(len[23:16], 1'b1);
    sendByte(len[15:8], 1'b1);
    sendByte(len[7:0], 1'b1);
    for (int k = 0; k < n; k++) sendByte(expByte(seed, k), k != badIdx);
    repeat (4 * BIT_CYC) @(negedge clk);
    check("R3 write count", wrCnt, n);
    check("R2 data and address", dataBad, 0);
    check("R4 single done pulse", doneCnt, 1);
    if (n > 0) check("R4 done follows last write", doneCyc - lastWrCyc, 1);
    check("R6 frame flag", int'(frameErr), int'(badIdx >= 0));
    for (int e = 0; e < extra; e++) sendByte(8'hA5 ^ 8'(e), e != 0);
    repeat (2 * BIT_CYC) @(negedge clk);
    if (extra > 0) begin
      check("R5 no write after done", wrAfterDone, 0);
      check("R5 no further done", doneCnt, 1);
      check("R5 flag unchanged", int'(frameErr), int'(badIdx >= 0));
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    runLoad(0, 1, -1, 2, 1'b0);    // R4 zero length, R5 ignore
    runLoad(1, 2, -1, 0, 1'b1);    // R7 glitch then R1 header
    runLoad(5, 3, 4, 2, 1'b0);     // R6 bad stop on last byte with done
    runLoad(3, 4, 0, 0, 1'b0);     // R6 bad stop early, sticky
    runLoad(260, 0, -1, 0, 1'b0);  // R1 middle header byte, R2 all values, wrap
    doReset();                     // R6 flag cleared by reset
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule